// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether one physical memory access may go ahead. It holds a small table of protection regions. Each region has an address register, a match mode, read, write and execute permission bits, and a lock bit. A requester presents an access: start address, byte count, requested permission, current privilege, a fetch flag, and two fields copied from machine status (the saved previous privilege and the modify-privilege enable). One clock later the block returns a registered allow or deny verdict.

The table is written through a plain write port. A write selects either the configuration byte or the address word of one region. A locked region ignores every such write until the next reset. Regions are scanned from the lowest index to the highest. The first region that the access touches decides the verdict. An access that lies only partly inside a region is refused.

A two-state machine sequences the result. In `ST_IDLE` no result is pending. When `chk_valid` is seen, the transition *capture* moves the machine to `ST_REPORT`, where `res_valid` is high for the captured verdict. From `ST_REPORT`, the transition *chain* keeps it in `ST_REPORT` if another check arrives, and *retire* returns it to `ST_IDLE` otherwise.

Top module: `pmp_guard`

## Requirements
- R1: After reset `res_valid` is 0, every region is in mode OFF and unlocked, and so a machine-mode access is allowed while any lower-mode access is denied.
- R2: A `chk_valid` strobe in cycle n gives `res_valid`=1 and the verdict on `res_allow` in cycle n+1. `res_valid` is 0 in every cycle that does not follow a strobe. Back-to-back strobes give back-to-back results.
- R3: Regions are evaluated from index 0 upward, and the lowest-indexed region the access touches alone decides the verdict.
- R4: An access is tested at its first byte (`chk_addr`) and its last byte (`chk_addr + chk_size - 1`). If exactly one of the two lies inside a region, that region decides and the access is denied, even in machine mode.
- R5: A region in mode OFF (code 0) never matches, whatever its address and permission bits.
- R6: When a region fully contains the access, the requested permission is checked against the region's bits if the effective privilege is not machine mode or the region is locked. Otherwise every permission is granted. `chk_perm` is one-hot: bit0 read, bit1 write, bit2 execute.
- R7: If no region matches, the access is allowed only when the effective privilege is machine mode (code 3). User is code 0 and supervisor is code 1.
- R8: For a data access (`chk_fetch`=0) at machine privilege with `st_mprv`=1, the effective privilege is `st_mpp`. An instruction fetch always uses `chk_priv`.
- R9: While a region's lock bit is set, writes to its configuration byte and its address word are ignored. Only reset clears the lock.
- R10: The configuration byte has read in bit0, write in bit1, execute in bit2, mode in bits 4:3 and lock in bit7. Mode TOR (1) covers byte addresses from the previous region's address×4 up to, but not including, this region's address×4; region 0 starts at 0. NA4 (2) covers the four bytes at address×4. NAPOT (3) with k trailing ones in the address word covers 2^(k+3) bytes aligned to that size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_is_addr | input | 1 | 1 writes the address word, 0 writes the configuration byte |
| cfg_idx | input | IDX_W | Region index written |
| cfg_wdata | input | ADDR_W-2 | Write data (configuration uses bits 7:0) |
| chk_valid | input | 1 | Access check strobe |
| chk_addr | input | ADDR_W | First byte address of the access |
| chk_size | input | SIZE_W | Access length in bytes, at least 1 |
| chk_perm | input | 3 | Requested permission, one-hot |
| chk_priv | input | 2 | Current privilege |
| chk_fetch | input | 1 | 1 for an instruction fetch |
| st_mpp | input | 2 | Saved previous privilege from machine status |
| st_mprv | input | 1 | Modify-privilege enable from machine status |
| res_valid | output | 1 | Verdict valid, one cycle after the strobe |
| res_allow | output | 1 | Registered verdict, 1 = allowed |

## Verification
The bench builds the block with its default parameters: eight regions, 32-bit addresses and a 4-bit size field. These settings allow a TOR region to take its base from an OFF neighbour. They also allow an NA4 region to overlap a TOR region at a lower index, so the priority order shows in the verdict. A 256-byte NAPOT region is tested at its interior and at the first byte past its end. Accesses that straddle a region edge are included. A locked region is then rewritten and later cleared by a second reset. The four-bit size field allows accesses that start inside one region and end outside it.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] spare;
        amode_e     mode;
        logic       x;
        logic       w;
        logic       r;
    } ecfg_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } gstate_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

endpackage

// File: rtl/pmpc_entry.sv
module pmpc_entry
    import pmpc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  ecfg_t             cfg,
    input  logic [ADDR_W-3:0] addr_w,
    input  logic [ADDR_W-3:0] prev_w,
    input  logic [ADDR_W-1:0] first_b,
    input  logic [ADDR_W-1:0] last_b,
    output logic              first_in,
    output logic              last_in
);
    localparam int WA_W = ADDR_W - 2;

    logic [WA_W-1:0]   napot_ign;
    logic [ADDR_W-1:0] lo_b;
    logic [ADDR_W-1:0] hi_b;

    // bits of the word address ignored by a NAPOT region: trailing ones plus the zero above
    assign napot_ign = addr_w ^ (addr_w + 1'b1);
    assign lo_b      = {prev_w, 2'b00};
    assign hi_b      = {addr_w, 2'b00};

    function automatic logic hit(input logic [ADDR_W-1:0] b);
        logic [WA_W-1:0] wd;
        wd = b[ADDR_W-1:2];
        unique case (cfg.mode)
            AM_TOR:   hit = (b >= lo_b) && (b < hi_b);
            AM_NA4:   hit = (wd == addr_w);
            AM_NAPOT: hit = (((wd ^ addr_w) & ~napot_ign) == '0);
            default:  hit = 1'b0;
        endcase
    endfunction

    assign first_in = hit(first_b);
    assign last_in  = hit(last_b);

endmodule

// File: rtl/pmpc_prio.sv
module pmpc_prio #(
    parameter int N_ENT = 8
) (
    input  logic [N_ENT-1:0]      first_in,
    input  logic [N_ENT-1:0]      last_in,
    input  logic [N_ENT-1:0][2:0] rwx,
    input  logic [N_ENT-1:0]      locked,
    input  logic                  eff_is_m,
    input  logic [2:0]            want,
    output logic [N_ENT-1:0]      winner,
    output logic                  no_match,
    output logic                  straddle,
    output logic                  allow
);
    always_comb begin
        logic       found;
        logic [2:0] grant;
        found    = 1'b0;
        winner   = '0;
        straddle = 1'b0;
        grant    = 3'b000;
        for (int i = 0; i < N_ENT; i++) begin
            if (!found && (first_in[i] || last_in[i])) begin
                found     = 1'b1;
                winner[i] = 1'b1;
                straddle  = first_in[i] ^ last_in[i];
                grant     = (!eff_is_m || locked[i]) ? rwx[i] : 3'b111;
            end
        end
        no_match = !found;
        if (!found)        allow = eff_is_m;
        else if (straddle) allow = 1'b0;
        else               allow = ((want & ~grant) == 3'b000);
    end

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
    import pmpc_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int WA_W  = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_is_addr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [WA_W-1:0]   cfg_wdata,
    input  logic              chk_valid,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [SIZE_W-1:0] chk_size,
    input  logic [2:0]        chk_perm,
    input  logic [1:0]        chk_priv,
    input  logic              chk_fetch,
    input  logic [1:0]        st_mpp,
    input  logic              st_mprv,
    output logic              res_valid,
    output logic              res_allow
);
    ecfg_t                 cfg_q  [N_ENT];
    logic [WA_W-1:0]       addr_q [N_ENT];
    logic [N_ENT-1:0]      first_in, last_in, locked, winner;
    logic [N_ENT-1:0][2:0] rwx;
    logic [ADDR_W-1:0]     last_b;
    logic [1:0]            eff_priv;
    logic                  no_match, straddle, allow_c;
    gstate_e               state_q, state_d;
    logic                  allow_q;

    // table write port: a locked region keeps its contents until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) begin
                cfg_q[i]  <= '0;
                addr_q[i] <= '0;
            end
        end else if (cfg_we && (int'(cfg_idx) < N_ENT) && !cfg_q[cfg_idx].lock) begin
            if (cfg_is_addr) addr_q[cfg_idx] <= cfg_wdata;
            else             cfg_q[cfg_idx]  <= ecfg_t'(cfg_wdata[7:0]);
        end
    end

    assign last_b   = chk_addr + {{(ADDR_W-SIZE_W){1'b0}}, chk_size} - 1'b1;
    assign eff_priv = (!chk_fetch && st_mprv && chk_priv == PRIV_M) ? st_mpp : chk_priv;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic [WA_W-1:0] prev_w;
        if (g == 0) begin : g_base
            assign prev_w = '0;
        end else begin : g_prev
            assign prev_w = addr_q[g-1];
        end
        pmpc_entry #(.ADDR_W(ADDR_W)) u_ent (
            .cfg      (cfg_q[g]),
            .addr_w   (addr_q[g]),
            .prev_w   (prev_w),
            .first_b  (chk_addr),
            .last_b   (last_b),
            .first_in (first_in[g]),
            .last_in  (last_in[g])
        );
        assign rwx[g]    = {cfg_q[g].x, cfg_q[g].w, cfg_q[g].r};
        assign locked[g] = cfg_q[g].lock;

        assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cfg_q[g].lock) |-> ($stable(cfg_q[g]) && $stable(addr_q[g])));
    end

    pmpc_prio #(.N_ENT(N_ENT)) u_prio (
        .first_in (first_in),
        .last_in  (last_in),
        .rwx      (rwx),
        .locked   (locked),
        .eff_is_m (eff_priv == PRIV_M),
        .want     (chk_perm),
        .winner   (winner),
        .no_match (no_match),
        .straddle (straddle),
        .allow    (allow_c)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = chk_valid ? ST_REPORT : ST_IDLE;   // capture
            ST_REPORT: state_d = chk_valid ? ST_REPORT : ST_IDLE;   // chain / retire
            default:   state_d = ST_IDLE;
        endcase
    end

    // output process: verdict captured with the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)         allow_q <= 1'b0;
        else if (chk_valid) allow_q <= allow_c;
    end

    assign res_valid = (state_q == ST_REPORT);
    assign res_allow = allow_q;

    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !res_valid);
    assert_single_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(winner));
    assert_straddle_denied_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && straddle) |=> !res_allow);
    assert_unmatched_machine_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && no_match && eff_priv == PRIV_M) |=> res_allow);
    assert_unmatched_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && no_match && eff_priv != PRIV_M) |=> !res_allow);

endmodule

// File: tb/sim_pmp_guard.sv
module sim_pmp_guard;
    localparam int CLK_NS = 10;
    localparam int N_ENT  = 8;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 4;
    localparam int IDX_W  = 3;
    localparam int WA_W   = ADDR_W - 2;

    localparam logic [2:0] PR = 3'b001, PW = 3'b010, PX = 3'b100;
    localparam logic [1:0] MU = 2'd0, MM = 2'd3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0, cfg_is_addr = 1'b0;
    logic [IDX_W-1:0]  cfg_idx = '0;
    logic [WA_W-1:0]   cfg_wdata = '0;
    logic              chk_valid = 1'b0;
    logic [ADDR_W-1:0] chk_addr = '0;
    logic [SIZE_W-1:0] chk_size = 4'd1;
    logic [2:0]        chk_perm = 3'b001;
    logic [1:0]        chk_priv = 2'd3;
    logic              chk_fetch = 1'b0;
    logic [1:0]        st_mpp = 2'd0;
    logic              st_mprv = 1'b0;
    logic              res_valid, res_allow;

    int    checks = 0, failures = 0, cyc = 0;
    bit    exp_q[$];
    int    due_q[$];
    string tag_q[$];

    pmp_guard #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_is_addr(cfg_is_addr),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .chk_valid(chk_valid),
        .chk_addr(chk_addr), .chk_size(chk_size), .chk_perm(chk_perm),
        .chk_priv(chk_priv), .chk_fetch(chk_fetch), .st_mpp(st_mpp),
        .st_mprv(st_mprv), .res_valid(res_valid), .res_allow(res_allow));

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R2 unexpected result: res_valid=1 expected=0");
            end else begin
                bit    e;
                int    d;
                string t;
                e = exp_q.pop_front();
                d = due_q.pop_front();
                t = tag_q.pop_front();
                if (res_allow !== e || cyc != d) begin
                    failures++;
                    $display("FAIL %s: allow=%0b cycle=%0d expected allow=%0b cycle=%0d",
                             t, res_allow, cyc, e, d);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input bit is_addr, input int idx, input logic [WA_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_is_addr = is_addr; cfg_idx = IDX_W'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic chk(input logic [ADDR_W-1:0] a, input int sz, input logic [2:0] p,
                       input logic [1:0] pv, input bit f, input logic [1:0] mpp,
                       input bit mprv, input bit e, input string t);
        @(negedge clk);
        chk_valid = 1'b1; chk_addr = a; chk_size = SIZE_W'(sz); chk_perm = p;
        chk_priv = pv; chk_fetch = f; st_mpp = mpp; st_mprv = mprv;
        exp_q.push_back(e); due_q.push_back(cyc + 1); tag_q.push_back(t);
    endtask

    task automatic idle();
        @(negedge clk);
        chk_valid = 1'b0;
    endtask

    task automatic one(input logic [ADDR_W-1:0] a, input int sz, input logic [2:0] p,
                       input logic [1:0] pv, input bit e, input string t);
        chk(a, sz, p, pv, 1'b0, MU, 1'b0, e, t);
        idle();
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R2 missing results: pending=%0d expected=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 20000);
        failures++;
        $display("FAIL watchdog expired: finished=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        checks++;
        if (res_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: res_valid=%0b expected=0", res_valid);
        end
        one(32'h100, 4, PR, MM, 1'b1, "R1 empty table machine read");
        one(32'h100, 4, PR, MU, 1'b0, "R1 empty table user read");

        // region 0 NA4 at 0x100 read only; region 1 TOR 0x100..0x1FF rw
        wr(1'b1, 0, 30'h40);  wr(1'b0, 0, 30'h11);
        wr(1'b1, 1, 30'h80);  wr(1'b0, 1, 30'h0B);
        // region 2 NAPOT 0x1000..0x10FF execute only
        wr(1'b1, 2, 30'h41F); wr(1'b0, 2, 30'h1C);
        // region 3 OFF with all bits; region 4 TOR from region 3 address
        wr(1'b1, 3, 30'h800); wr(1'b0, 3, 30'h07);
        wr(1'b1, 4, 30'hC00); wr(1'b0, 4, 30'h0F);

        one(32'h100, 4, PW, MU, 1'b0, "R3 lower NA4 region wins over TOR");
        one(32'h104, 4, PW, MU, 1'b1, "R6 user write in TOR rw region");
        one(32'h104, 4, PX, MU, 1'b0, "R6 user exec in TOR rw region");
        one(32'h1FE, 4, PR, MU, 1'b0, "R4 straddles TOR top, user");
        one(32'h1FE, 4, PR, MM, 1'b0, "R4 straddles TOR top, machine");
        one(32'h102, 4, PR, MU, 1'b0, "R4 first byte only in NA4");
        one(32'h10F0, 4, PX, MU, 1'b1, "R10 NAPOT interior exec");
        one(32'h10F0, 4, PR, MU, 1'b0, "R6 NAPOT read refused");
        one(32'h1100, 4, PX, MU, 1'b0, "R7 past NAPOT user");
        one(32'h1100, 4, PR, MM, 1'b1, "R7 past NAPOT machine");
        one(32'h1000, 4, PW, MM, 1'b1, "R6 unlocked region machine all granted");
        one(32'h1FF0, 4, PR, MU, 1'b0, "R5 OFF region never matches");
        one(32'h2000, 4, PR, MU, 1'b1, "R10 TOR base from OFF neighbour");

        // region 5 NA4 at 0x4000 locked read only
        wr(1'b1, 5, 30'h1000); wr(1'b0, 5, 30'h91);
        one(32'h4000, 4, PW, MM, 1'b0, "R6 locked region binds machine");
        one(32'h4000, 4, PR, MM, 1'b1, "R6 locked region machine read");
        chk(32'h5000, 4, PR, MM, 1'b0, MU, 1'b1, 1'b0, "R8 data uses saved user mode");
        chk(32'h5000, 4, PX, MM, 1'b1, MU, 1'b1, 1'b1, "R8 fetch keeps machine mode");
        chk(32'h5000, 4, PR, MM, 1'b0, MM, 1'b1, 1'b1, "R8 saved machine mode");
        chk(32'h5000, 4, PR, MU, 1'b0, MM, 1'b1, 1'b0, "R8 user current mode ignores saved");
        idle();

        wr(1'b0, 5, 30'h17);
        wr(1'b1, 5, 30'h1400);
        one(32'h4000, 4, PW, MM, 1'b0, "R9 locked cfg write ignored");
        one(32'h4000, 4, PR, MU, 1'b1, "R9 locked addr write ignored");
        one(32'h5000, 4, PR, MU, 1'b0, "R9 new address not taken");

        do_reset();
        one(32'h4000, 4, PR, MU, 1'b0, "R9 reset clears locked region");
        one(32'h4000, 4, PW, MM, 1'b1, "R1 machine allowed after reset");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule